// File: doc/BRIEF.md
# Logarithmic-Depth Unsigned Greater-Than Comparator

This block decides whether one unsigned integer is strictly larger than another. It is purely combinational and uses no subtractor. Every bit position first yields a small two-bit verdict: "this bit of the first operand wins" or "these bits tie". Those verdicts are then folded together pairwise in a balanced binary tree, from the least significant end to the most significant end. At each merge the higher-order half decides unless it ties, and in that case the lower-order half decides.

The tree needs log2(WIDTH) merge levels, so the path from any input bit to the output grows with the logarithm of the width. The number of cells grows linearly, with WIDTH leaves and WIDTH-1 merge nodes. The width is a parameter and must be a power of two; any other value stops elaboration. The default width is 8, which gives three merge levels.

Top module: `ucmp_gt_log`

## Requirements
- R1: With both operands read as unsigned WIDTH-bit integers, `gt_o` is 1 exactly when `a_i` is strictly greater than `b_i`, for every input pair.
- R2: When `a_i` equals `b_i`, `gt_o` is 0, including both all-zero and both all-ones.
- R3: All ones on `a_i` against all zeros on `b_i` gives 1, and the reverse gives 0.
- R4: The comparison is unsigned: an operand whose most significant bit is set is larger than any operand whose most significant bit is clear. For example, 0x80 against 0x7F gives 1.
- R5: Let k be the most significant bit position where the operands differ. Then `gt_o` equals `a_i[k]`, whatever the bits below k hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |

## Verification
Immediate assertions check three things whenever the inputs change. Every leaf and every merge node keeps "wins" and "ties" mutually exclusive. A non-tied upper half alone sets the merged verdict. The output is never high for equal operands, and never high when the operands are ordered the other way. These checks confirm that the tree stays self-consistent. They cannot show that the leaves are wired to the right bit positions, or that the upper and lower halves are given the correct roles. Only the bench's full sweep of all operand pairs against an arithmetic comparison shows that. Directed cases pin down the tie, extreme, sign-bit and highest-differing-bit behaviour.

// File: rtl/ucmp_pkg.sv
package ucmp_pkg;

   // Partial verdict for a group of bit positions.
   typedef struct packed {
      logic gt;   // group of a is larger than group of b
      logic eq;   // groups are identical
   } cmp_pair_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ucmp_leaf.sv
module ucmp_leaf
   import ucmp_pkg::*;
(
   input  logic      a_bit,
   input  logic      b_bit,
   output cmp_pair_t pair_o
);

   always_comb begin
      pair_o.gt = a_bit & ~b_bit;
      pair_o.eq = ~(a_bit ^ b_bit);
   end

   always_comb begin
      AST_LEAF_EXCL: assert (!(pair_o.gt && pair_o.eq)) else $error("leaf gt and eq both set"); // R1
      AST_LEAF_TIE: assert ((a_bit != b_bit) || pair_o.eq) else $error("leaf tie lost"); // R2
   end

endmodule

// File: rtl/ucmp_node.sv
module ucmp_node
   import ucmp_pkg::*;
(
   input  cmp_pair_t hi_i,
   input  cmp_pair_t lo_i,
   output cmp_pair_t pair_o
);

   always_comb begin
      pair_o.gt = hi_i.gt | (hi_i.eq & lo_i.gt);
      pair_o.eq = hi_i.eq & lo_i.eq;
   end

   always_comb begin
      AST_NODE_EXCL: assert (!(pair_o.gt && pair_o.eq)) else $error("node gt and eq both set"); // R1
      AST_HI_DECIDES: assert (hi_i.eq || (pair_o.gt == hi_i.gt)) else $error("upper half overridden"); // R5
      AST_TIE_PASSES: assert (!hi_i.eq || (pair_o.gt == lo_i.gt)) else $error("lower half ignored on tie"); // R5
   end

endmodule

// File: rtl/ucmp_gt_log.sv
module ucmp_gt_log
   import ucmp_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             gt_o
);

   localparam int unsigned LEVELS = $clog2(WIDTH);

   if (!is_pow2(WIDTH)) begin : g_bad_width
      $error("ucmp_gt_log: WIDTH must be a power of two");
   end

   // Level 0 holds one pair per bit; level l holds WIDTH>>l pairs,
   // index k covering bits [k*2^l +: 2^l].
   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int unsigned CNT = WIDTH >> l;
      cmp_pair_t [CNT-1:0] pair_w;

      if (l == 0) begin : g_leaf
         for (genvar j = 0; j < CNT; j++) begin : g_bit
            ucmp_leaf u_leaf (
               .a_bit  (a_i[j]),
               .b_bit  (b_i[j]),
               .pair_o (pair_w[j])
            );
         end
      end else begin : g_merge
         for (genvar k = 0; k < CNT; k++) begin : g_node
            ucmp_node u_node (
               .hi_i   (g_lvl[l-1].pair_w[2*k+1]),
               .lo_i   (g_lvl[l-1].pair_w[2*k]),
               .pair_o (pair_w[k])
            );
         end
      end
   end

   assign gt_o = g_lvl[LEVELS].pair_w[0].gt;

   always_comb begin
      AST_EQUAL_LOW: assert ((a_i != b_i) || !gt_o) else $error("gt on equal operands"); // R2
      AST_LESS_LOW: assert (!(a_i < b_i) || !gt_o) else $error("gt when a below b"); // R1
      AST_MSB_WINS: assert (!(a_i[WIDTH-1] && !b_i[WIDTH-1]) || gt_o) else $error("msb not decisive"); // R4
   end

endmodule

// File: tb/ucmp_gt_log_tb.sv
module ucmp_gt_log_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_s = '0;
   logic [W-1:0] b_s = '0;
   logic         gt_s;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ucmp_gt_log #(.WIDTH(W)) u_dut (
      .a_i  (a_s),
      .b_i  (b_s),
      .gt_o (gt_s)
   );

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
      @(posedge clk);
      a_s = a;
      b_s = b;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      checks++;
      if (gt_s !== exp) begin
         errors++;
         $display("FAIL %s a=%0h b=%0h got=%0b exp=%0b", req, a_s, b_s, gt_s, exp);
      end
   endtask

   initial begin
      #200000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Initial state: both operands zero
      apply('0, '0);
      check("R2", 1'b0);

      // R2 ties
      apply('1, '1);
      check("R2", 1'b0);
      apply(8'h5A, 8'h5A);
      check("R2", 1'b0);

      // R3 extremes
      apply('1, '0);
      check("R3", 1'b1);
      apply('0, '1);
      check("R3", 1'b0);

      // R4 unsigned sign bit
      apply(8'h80, 8'h7F);
      check("R4", 1'b1);
      apply(8'h7F, 8'h80);
      check("R4", 1'b0);
      apply(8'hFF, 8'h01);
      check("R4", 1'b1);

      // R5 highest differing bit decides, lower bits opposite
      for (int k = 0; k < W; k++) begin
         logic [W-1:0] lowm, hi, base;
         lowm = (W'(1) << k) - W'(1);
         hi   = ~((W'(1) << (k + 1)) - W'(1));
         base = 8'hA5 & hi;
         apply(base | (W'(1) << k), base | lowm);
         check("R5", 1'b1);
         apply(base | lowm, base | (W'(1) << k));
         check("R5", 1'b0);
      end

      // R1 exhaustive sweep against arithmetic compare
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            apply(W'(a), W'(b));
            check("R1", (a > b) ? 1'b1 : 1'b0);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule